// File: doc/BRIEF.md
# Timer Compare Output Unit with Software Force

This block owns two waveform output pins (channel A and channel B) of an 8-bit timer/counter. For each channel it receives a one-cycle compare-match pulse from the counter and a 2-bit action code. When a match arrives, the unit changes its pin as the code says and raises that channel's interrupt flag. Software can also make a forced match. It writes a strobe bit into the control register, and the pin then takes the same action right away without waiting for the counter.

A forced match is a pin-only event. It never raises a flag. It never asks the counter to restart in clear-on-match operation, and it reads back as zero. When the timer runs a PWM waveform mode, the force strobe is ignored and this unit leaves the pins alone, because PWM shaping happens elsewhere. The counter, the PWM waveform logic and clock selection sit outside the block.

Top module: `cmp_out_unit`

## Requirements
- R1: After a synchronous active-low reset, both pins are 0, both flags are 0, both action codes are 00, and the control readback is 0x00.
- R2: On a real match in non-PWM operation, the channel pin changes at the next clock edge according to the action code. 00 leaves the pin unchanged, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R3: A real match sets the channel flag at the next clock edge. This happens in PWM and in non-PWM operation.
- R4: Writing 1 to a channel bit of `flag_clr` (bit 0 for A, bit 1 for B) clears that flag at the next edge. When a real match arrives in the same cycle, the set wins.
- R5: A control write with bit 7 (channel A) or bit 6 (channel B) at 1 forces a match. The pin takes the action selected by the code carried in that same write, at the next edge.
- R6: A forced match never sets or changes a flag.
- R7: `cnt_clear` is high in the same cycle as a real channel-A match while `ctc_en` is high, and only then. A forced match never raises it.
- R8: While `pwm_mode` is 1, force strobes are ignored and neither pin changes. Real matches still set flags.
- R9: The control readback returns 0 in bits 7:6, the stored channel-A code in bits 5:4, the stored channel-B code in bits 3:2, and 0 in bits 1:0.
- R10: When a force strobe and a real match hit the same channel in the same cycle, the action is applied once, and the flag is set because of the real match.
- R11: An action code written in a cycle governs any match (real or forced) on that channel in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | 8 | Write data: [7] force A, [6] force B, [5:4] code A, [3:2] code B |
| ctrl_rd_data | output | 8 | Control register readback |
| pwm_mode | input | 1 | 1 = a PWM waveform mode is active |
| ctc_en | input | 1 | 1 = counter clears on channel-A match |
| match_a | input | 1 | Real compare-match pulse, channel A |
| match_b | input | 1 | Real compare-match pulse, channel B |
| flag_clr | input | 2 | Write-one-to-clear for flags, [0] A, [1] B |
| oc_a | output | 1 | Waveform pin, channel A |
| oc_b | output | 1 | Waveform pin, channel B |
| flag_a | output | 1 | Compare interrupt flag, channel A |
| flag_b | output | 1 | Compare interrupt flag, channel B |
| cnt_clear | output | 1 | Request to clear the counter |

## Verification
A wrong pin register or action decode shows on `oc_a`/`oc_b` one edge after the match or force that should have moved it. A force that leaks into the flag or counter-clear path shows on `flag_*` one edge later, or on `cnt_clear` in the same cycle. A corrupted stored code is visible at once on `ctrl_rd_data` and changes the response to the next match. A reference model in the bench compares every output on every clock, under directed cases and random traffic, so any of these shows within one cycle of its cause.

// File: rtl/cou_pkg.sv
// Shared types for the compare output unit.
// Holds the 2-bit action code and the pure function that applies it to a pin.
package cou_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_code_e;

    // Next pin value for a match event under the given action code.
    function automatic logic apply_action(act_code_e code, logic pin);
        logic nxt;
        case (code)
            ACT_TOGGLE: nxt = ~pin;
            ACT_LOW:    nxt = 1'b0;
            ACT_HIGH:   nxt = 1'b1;
            default:    nxt = pin;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/cou_ctrl_reg.sv
// Control register for the compare output unit.
// Stores one action code per channel and decodes the per-channel force strobes.
// Assumes channel c has its force bit at FORCE_MSB-c and its code field
// at CODE_MSB-2c down to CODE_MSB-2c-1. Force bits are never stored.
// The effective code forwards a code being written in the same cycle.
module cou_ctrl_reg #(
    parameter int DATA_W    = 8,
    parameter int NUM_CH    = 2,
    parameter int FORCE_MSB = 7,
    parameter int CODE_MSB  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic [NUM_CH-1:0]      force_o,
    output cou_pkg::act_code_e     code_eff_o [NUM_CH]
);
    import cou_pkg::*;

    localparam int CODE_W = 2;

    act_code_e code_q [NUM_CH];
    logic [DATA_W-1:0] rd_mask;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int FBIT = FORCE_MSB - c;
        localparam int CLSB = CODE_MSB - CODE_W*c - (CODE_W-1);

        // Hold the channel action code across cycles.
        always_ff @(posedge clk) begin
            if (!rst_n)       code_q[c] <= ACT_HOLD;
            else if (wr_en_i) code_q[c] <= act_code_e'(wr_data_i[CLSB +: CODE_W]);
        end

        // Forward a code written this cycle so it governs this cycle's event.
        assign code_eff_o[c] = wr_en_i ? act_code_e'(wr_data_i[CLSB +: CODE_W]) : code_q[c];

        // The force bit acts only as a strobe on the write cycle.
        assign force_o[c] = wr_en_i & wr_data_i[FBIT];
    end

    // Assemble the readback from stored codes; all other bits read zero.
    always_comb begin
        rd_data_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            rd_data_o[CODE_MSB - CODE_W*c -: CODE_W] = code_q[c];
        end
    end

    // Mask of bits that are not code fields, for the readback check.
    always_comb begin
        rd_mask = '1;
        for (int c = 0; c < NUM_CH; c++) begin
            rd_mask[CODE_MSB - CODE_W*c -: CODE_W] = '0;
        end
    end

    // R9: force strobes and reserved bits never show in the readback.
    a_r9_rd_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (rd_data_o & rd_mask) == '0);

    // R11: a stored code equals the code carried by the last write.
    a_r11_code_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> rd_data_o[CODE_MSB -: CODE_W] == $past(wr_data_i[CODE_MSB -: CODE_W]));

endmodule

// File: rtl/cou_channel.sv
// One compare output channel: the waveform pin and its interrupt flag.
// Assumes match_i and force_i are single-cycle pulses and code_i already
// reflects any code written in the same cycle. In PWM operation the pin
// is left to external PWM logic, so this channel holds it.
module cou_channel (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwm_i,
    input  logic               match_i,
    input  logic               force_i,
    input  logic               flag_clr_i,
    input  cou_pkg::act_code_e code_i,
    output logic               oc_o,
    output logic               flag_o
);
    import cou_pkg::*;

    logic pin_event;

    // A real or forced match merges into one event, so it acts once.
    assign pin_event = (match_i | force_i) & ~pwm_i;

    // Update the waveform pin on a merged match event.
    always_ff @(posedge clk) begin
        if (!rst_n)         oc_o <= 1'b0;
        else if (pin_event) oc_o <= apply_action(code_i, oc_o);
    end

    // Set the flag on real matches only; write-one clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_o <= 1'b0;
        else if (match_i)    flag_o <= 1'b1;
        else if (flag_clr_i) flag_o <= 1'b0;
    end

    // R6: the flag can only rise after a real match.
    a_r6_flag_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(match_i));

    // R3: a real match leaves the flag set.
    a_r3_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> flag_o);

    // R4: a clear without a match drops the flag.
    a_r4_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !match_i) |=> !flag_o);

    // R8: the pin holds in PWM operation.
    a_r8_pwm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_i |=> $stable(oc_o));

    // R2: the hold code leaves the pin unchanged.
    a_r2_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == ACT_HOLD) |=> $stable(oc_o));

endmodule

// File: rtl/cmp_out_unit.sv
// Compare output unit top: control register plus one channel per output.
// Assumes the counter supplies single-cycle match pulses. cnt_clear is
// a same-cycle request to the counter, driven by real channel-A matches only.
module cmp_out_unit #(
    parameter int DATA_W    = 8,
    parameter int FORCE_MSB = 7,
    parameter int CODE_MSB  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_en,
    input  logic [DATA_W-1:0] ctrl_wr_data,
    output logic [DATA_W-1:0] ctrl_rd_data,
    input  logic              pwm_mode,
    input  logic              ctc_en,
    input  logic              match_a,
    input  logic              match_b,
    input  logic [1:0]        flag_clr,
    output logic              oc_a,
    output logic              oc_b,
    output logic              flag_a,
    output logic              flag_b,
    output logic              cnt_clear
);
    import cou_pkg::*;

    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0] force_s;
    logic [NUM_CH-1:0] match_s;
    logic [NUM_CH-1:0] oc_s;
    logic [NUM_CH-1:0] flag_s;
    act_code_e         code_s [NUM_CH];

    assign match_s = {match_b, match_a};

    cou_ctrl_reg #(
        .DATA_W    (DATA_W),
        .NUM_CH    (NUM_CH),
        .FORCE_MSB (FORCE_MSB),
        .CODE_MSB  (CODE_MSB)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (ctrl_wr_en),
        .wr_data_i  (ctrl_wr_data),
        .rd_data_o  (ctrl_rd_data),
        .force_o    (force_s),
        .code_eff_o (code_s)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        cou_channel u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .pwm_i      (pwm_mode),
            .match_i    (match_s[c]),
            .force_i    (force_s[c]),
            .flag_clr_i (flag_clr[c]),
            .code_i     (code_s[c]),
            .oc_o       (oc_s[c]),
            .flag_o     (flag_s[c])
        );
    end

    assign oc_a   = oc_s[0];
    assign oc_b   = oc_s[1];
    assign flag_a = flag_s[0];
    assign flag_b = flag_s[1];

    // The counter restart request follows real channel-A matches only.
    assign cnt_clear = ctc_en & match_a;

    // R7: a force without a real match never requests a counter clear.
    a_r7_force_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (force_s[0] && !match_a) |-> !cnt_clear);

    // R5: a non-PWM force with the high code drives the pin to 1.
    a_r5_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        (force_s[0] && !pwm_mode && code_s[0] == ACT_HIGH) |=> oc_a);

endmodule

// File: tb/cmp_out_unit_bench.sv
`timescale 1ns/1ps
module cmp_out_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pwm = 1'b0, ctc = 1'b0, ma = 1'b0, mb = 1'b0;
    logic [1:0] clr = '0;
    logic       oc_a, oc_b, flag_a, flag_b, cnt_clear;

    int checks = 0, errors = 0;
    bit chk_en = 0;

    // Behavioural reference state.
    int m_oc[2], m_flag[2], m_code[2];

    always #2 clk = ~clk;

    cmp_out_unit u_cmp_out_unit (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_en(wr_en), .ctrl_wr_data(wr_data),
        .ctrl_rd_data(rd_data), .pwm_mode(pwm), .ctc_en(ctc), .match_a(ma),
        .match_b(mb), .flag_clr(clr), .oc_a(oc_a), .oc_b(oc_b),
        .flag_a(flag_a), .flag_b(flag_b), .cnt_clear(cnt_clear)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ctl(int fa, int fb, int ca, int cb);
        return 8'((fa << 7) | (fb << 6) | (ca << 4) | (cb << 2));
    endfunction

    // Reference model: advance at each clock edge from the held inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin m_oc[c] = 0; m_flag[c] = 0; m_code[c] = 0; end
        end else begin
            for (int c = 0; c < 2; c++) begin
                int code, frc, mt;
                code = wr_en ? ((wr_data >> (4 - 2*c)) & 3) : m_code[c];
                frc  = wr_en ? ((wr_data >> (7 - c)) & 1) : 0;
                mt   = (c == 0) ? ma : mb;
                if (!pwm && (mt || frc)) begin
                    if (code == 1) m_oc[c] = 1 - m_oc[c];
                    else if (code == 2) m_oc[c] = 0;
                    else if (code == 3) m_oc[c] = 1;
                end
                if (mt) m_flag[c] = 1;
                else if (clr[c]) m_flag[c] = 0;
                if (wr_en) m_code[c] = code;
            end
        end
    end

    // Compare every output at each falling edge.
    always @(negedge clk) begin
        if (chk_en) begin
            chk("R2 oc_a", oc_a, m_oc[0]);
            chk("R2 oc_b", oc_b, m_oc[1]);
            chk("R3 flag_a", flag_a, m_flag[0]);
            chk("R3 flag_b", flag_b, m_flag[1]);
            chk("R7 cnt_clear", cnt_clear, ctc & ma);
            chk("R9 readback", rd_data, (m_code[0] << 4) | (m_code[1] << 2));
        end
    end

    // Hold one set of inputs for one cycle, applied just after the edge.
    task automatic step(logic w, logic [7:0] d, logic a, logic b, logic [1:0] cl);
        @(posedge clk); #1;
        wr_en = w; wr_data = d; ma = a; mb = b; clr = cl;
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 1'b0, 1'b0, 2'b00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_en = 1;
        chk("R1 oc_a", oc_a, 0); chk("R1 oc_b", oc_b, 0);
        chk("R1 flags", {flag_b, flag_a}, 0); chk("R1 readback", rd_data, 0);

        step(1, ctl(0,0,1,3), 0, 0, 0); idle();
        chk("R9 codes", rd_data, 8'h1C);
        step(0, 0, 1, 0, 0); idle();
        chk("R2 toggle", oc_a, 1); chk("R3 flag_a", flag_a, 1);
        step(0, 0, 0, 1, 0); idle();
        chk("R2 high", oc_b, 1); chk("R3 flag_b", flag_b, 1);

        step(0, 0, 0, 0, 2'b01); idle();
        chk("R4 clear", flag_a, 0);
        step(0, 0, 1, 0, 2'b01); idle();
        chk("R4 set wins", flag_a, 1); chk("R2 toggle back", oc_a, 0);
        step(0, 0, 0, 0, 2'b11); idle();

        step(1, ctl(1,0,3,3), 0, 0, 0); idle();
        chk("R5 force A high", oc_a, 1); chk("R6 no flag A", flag_a, 0);
        chk("R9 strobe reads zero", rd_data, 8'h3C);
        step(1, ctl(0,1,3,2), 0, 0, 0); idle();
        chk("R5 force B low", oc_b, 0); chk("R6 no flag B", flag_b, 0);

        ctc = 1;
        step(1, ctl(1,0,1,2), 0, 0, 0); #1;
        chk("R7 force no clear", cnt_clear, 0);
        idle(); chk("R5 force toggle", oc_a, 0);
        step(0, 0, 1, 0, 0); #1;
        chk("R7 match clears", cnt_clear, 1);
        idle(); ctc = 0;
        chk("R2 toggle", oc_a, 1);
        step(0, 0, 0, 0, 2'b11); idle();

        pwm = 1;
        step(1, ctl(1,1,1,1), 0, 0, 0); idle();
        chk("R8 force ignored A", oc_a, 1); chk("R8 force ignored B", oc_b, 0);
        step(0, 0, 1, 0, 0); idle();
        chk("R8 pin held", oc_a, 1); chk("R8 flag still set", flag_a, 1);
        pwm = 0;
        step(0, 0, 0, 0, 2'b01); idle();

        step(1, ctl(1,0,1,1), 1, 0, 0); idle();
        chk("R10 single toggle", oc_a, 0); chk("R10 flag", flag_a, 1);
        step(0, 0, 0, 0, 2'b01); idle();

        step(1, ctl(1,0,1,1), 0, 0, 0); idle();
        step(1, ctl(0,0,3,1), 1, 0, 0); idle();
        chk("R11 same-cycle code", oc_a, 1);

        step(1, ctl(0,0,0,0), 0, 0, 0); step(0, 0, 1, 1, 0); idle();
        chk("R2 hold A", oc_a, 1); chk("R2 hold B", oc_b, 0);
        step(1, ctl(1,1,0,0), 0, 0, 0); idle();
        chk("R2 force hold", oc_a, 1);

        for (int i = 0; i < 600; i++) begin
            pwm = ($urandom % 4) == 0;
            ctc = $urandom % 2;
            step(($urandom % 3) == 0, 8'($urandom), ($urandom % 3) == 0,
                 ($urandom % 3) == 0, 2'($urandom));
        end
        idle(); idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule